// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block samples a free-running time counter at the moment a qualified packet's start-of-frame marker is seen, once for the transmit direction and once for the receive direction. Each direction owns a separate latch. A channel captures only while its enable input is high. Once it has captured, it locks and holds that single value until software has fetched it. This ties each stored stamp to exactly one packet.

Software reads a stamp as two 32-bit halves: the low half first, then the high half. A high-half read is the act that frees the channel. Reading only the low half leaves the lock in place. A qualifying event that arrives while a channel is locked is discarded and counted in a saturating missed-event counter. When a release read and a new event fall in the same cycle, the read returns the old stamp and the new event is captured. Dropping the enable clears the lock and the valid flag. To flush stale values during reconfiguration, read both halves on both channels.

Top module: `pkt_ts_latch`

## Requirements
- R1: While a channel's enable is low, events are not captured and the stored stamp is unchanged. A cycle with enable low clears that channel's valid flag, so the first enabled event afterwards is captured.
- R2: On a clock edge where enable and event are high and valid is low, the channel stores time_i from that cycle. Its valid output is high after that edge.
- R3: While valid is high, an event without a same-cycle high read is ignored. The stored stamp and valid stay unchanged.
- R4: A low-read strobe makes rdata show bits [31:0] of the stored stamp after the next edge. A high-read strobe makes it show bits [63:32]. If both strobes are high, the high read wins. Otherwise rdata holds its last value.
- R5: A high read without a same-cycle event clears valid after that edge.
- R6: A low read alone does not clear valid and does not release the lock.
- R7: Each event dropped under R3 increments the channel's missed counter by one. The counter saturates at its all-ones value, and only reset clears it.
- R8: When a high read and an event occur in the same enabled cycle, rdata returns the high half of the old stamp, the new time is stored, and valid stays high.
- R9: The transmit channel and the receive channel share only time_i. Activity on one channel never changes the other channel's outputs.
- R10: After reset, valid is low and rdata and the missed counter are zero on both channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| time_i | input | 64 | Time counter value to sample |
| tx_en_i | input | 1 | Transmit channel capture enable |
| tx_evt_i | input | 1 | Transmit qualified start-of-frame marker |
| tx_rd_lo_i | input | 1 | Transmit low-half read strobe |
| tx_rd_hi_i | input | 1 | Transmit high-half read strobe (releases lock) |
| tx_valid_o | output | 1 | Transmit stamp held |
| tx_rdata_o | output | 32 | Transmit read data |
| tx_missed_o | output | 8 | Transmit dropped-event count, saturating |
| rx_en_i | input | 1 | Receive channel capture enable |
| rx_evt_i | input | 1 | Receive qualified start-of-frame marker |
| rx_rd_lo_i | input | 1 | Receive low-half read strobe |
| rx_rd_hi_i | input | 1 | Receive high-half read strobe (releases lock) |
| rx_valid_o | output | 1 | Receive stamp held |
| rx_rdata_o | output | 32 | Receive read data |
| rx_missed_o | output | 8 | Receive dropped-event count, saturating |

## Verification
A lock flag that releases too early shows up as a stamp overwritten by a later event. The next low or high read, one cycle after the strobe, then returns a time that differs from the first captured packet's. A lock that never releases appears as valid stuck high and as missed counts that climb on events which should have been captured. Both are visible within one or two cycles of the offending event. A per-cycle reference model tracks valid, rdata and missed on both channels under dense pseudo-random enables, events and reads. Every divergence therefore surfaces in the cycle right after the edge that caused it.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int unsigned NUM_CH = 2;
  typedef enum logic {CH_TX = 1'b0, CH_RX = 1'b1} ts_ch_e;

  function automatic int unsigned ch_idx(ts_ch_e ch);
    return (ch == CH_TX) ? 0 : 1;
  endfunction
endpackage

// File: rtl/ts_lock_ctrl.sv
module ts_lock_ctrl #(
  parameter int unsigned MISS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              evt_i,
  input  logic              rel_i,
  output logic              cap_o,
  output logic              valid_o,
  output logic [MISS_W-1:0] missed_o
);
  localparam logic [MISS_W-1:0] MissMax = {MISS_W{1'b1}};

  logic valid_q;
  logic [MISS_W-1:0] miss_q;
  logic drop;

  // release read completes before a same-cycle event is taken
  assign cap_o = en_i & evt_i & (~valid_q | rel_i);
  assign drop  = en_i & evt_i & valid_q & ~rel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
    end else if (!en_i) begin
      valid_q <= 1'b0;
    end else if (cap_o) begin
      valid_q <= 1'b1;
    end else if (rel_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_q <= '0;
    end else if (drop && (miss_q != MissMax)) begin
      miss_q <= miss_q + MISS_W'(1);
    end
  end

  assign valid_o  = valid_q;
  assign missed_o = miss_q;

  p_dis_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);
  p_first_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i && !valid_o) |=> valid_o);
  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_o && rel_i && !evt_i) |=> !valid_o);
  p_lo_no_rel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_o && !rel_i) |=> valid_o);
  p_miss_inc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i && valid_o && !rel_i && (missed_o != MissMax))
      |=> (missed_o == $past(missed_o) + MISS_W'(1)));
  p_miss_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (missed_o == MissMax) |=> (missed_o == MissMax));
endmodule

// File: rtl/ts_stamp_store.sv
module ts_stamp_store #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [TIME_W-1:0] stamp_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned HI_W = TIME_W - WORD_W;

  logic [TIME_W-1:0] stamp_q;
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] hi_word;

  generate
    if (HI_W >= WORD_W) begin : g_hi_full
      assign hi_word = stamp_q[WORD_W +: WORD_W];
    end else begin : g_hi_pad
      assign hi_word = {{(WORD_W-HI_W){1'b0}}, stamp_q[TIME_W-1:WORD_W]};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_q <= '0;
    end else if (cap_i) begin
      stamp_q <= time_i;
    end
  end

  // read data reflects the stamp before any same-edge capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_hi_i) begin
      rdata_q <= hi_word;
    end else if (rd_lo_i) begin
      rdata_q <= stamp_q[WORD_W-1:0];
    end
  end

  assign stamp_o = stamp_q;
  assign rdata_o = rdata_q;

  p_rd_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo_i && !rd_hi_i) |=> (rdata_o == $past(stamp_o[WORD_W-1:0])));
  p_rd_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_lo_i && !rd_hi_i) |=> $stable(rdata_o));
endmodule

// File: rtl/ts_chan.sv
module ts_chan #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned MISS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              en_i,
  input  logic              evt_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [MISS_W-1:0] missed_o
);
  logic cap;
  logic [TIME_W-1:0] stamp;

  ts_lock_ctrl #(.MISS_W(MISS_W)) ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .evt_i   (evt_i),
    .rel_i   (rd_hi_i),
    .cap_o   (cap),
    .valid_o (valid_o),
    .missed_o(missed_o)
  );

  ts_stamp_store #(.TIME_W(TIME_W), .WORD_W(WORD_W)) store_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .time_i (time_i),
    .rd_lo_i(rd_lo_i),
    .rd_hi_i(rd_hi_i),
    .stamp_o(stamp),
    .rdata_o(rdata_o)
  );

  p_lock_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_o && !rd_hi_i) |=> (valid_o && $stable(stamp)));
  p_dis_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(stamp));
  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i && !valid_o) |=> (stamp == $past(time_i)));
  p_swap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i && valid_o && rd_hi_i) |=> (valid_o && (stamp == $past(time_i))));
endmodule

// File: rtl/pkt_ts_latch.sv
module pkt_ts_latch
  import ts_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned MISS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              tx_en_i,
  input  logic              tx_evt_i,
  input  logic              tx_rd_lo_i,
  input  logic              tx_rd_hi_i,
  output logic              tx_valid_o,
  output logic [WORD_W-1:0] tx_rdata_o,
  output logic [MISS_W-1:0] tx_missed_o,
  input  logic              rx_en_i,
  input  logic              rx_evt_i,
  input  logic              rx_rd_lo_i,
  input  logic              rx_rd_hi_i,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_rdata_o,
  output logic [MISS_W-1:0] rx_missed_o
);
  localparam int unsigned TX = ch_idx(CH_TX);
  localparam int unsigned RX = ch_idx(CH_RX);

  logic [NUM_CH-1:0] en, evt, rd_lo, rd_hi, valid;
  logic [WORD_W-1:0] rdata  [NUM_CH];
  logic [MISS_W-1:0] missed [NUM_CH];

  assign en[TX]    = tx_en_i;
  assign evt[TX]   = tx_evt_i;
  assign rd_lo[TX] = tx_rd_lo_i;
  assign rd_hi[TX] = tx_rd_hi_i;
  assign en[RX]    = rx_en_i;
  assign evt[RX]   = rx_evt_i;
  assign rd_lo[RX] = rx_rd_lo_i;
  assign rd_hi[RX] = rx_rd_hi_i;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ts_chan #(.TIME_W(TIME_W), .WORD_W(WORD_W), .MISS_W(MISS_W)) chan_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .time_i  (time_i),
        .en_i    (en[c]),
        .evt_i   (evt[c]),
        .rd_lo_i (rd_lo[c]),
        .rd_hi_i (rd_hi[c]),
        .valid_o (valid[c]),
        .rdata_o (rdata[c]),
        .missed_o(missed[c])
      );
    end
  endgenerate

  assign tx_valid_o  = valid[TX];
  assign tx_rdata_o  = rdata[TX];
  assign tx_missed_o = missed[TX];
  assign rx_valid_o  = valid[RX];
  assign rx_rdata_o  = rdata[RX];
  assign rx_missed_o = missed[RX];

  p_rx_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i) |=> (!rx_valid_o && $stable(rx_missed_o)));
  p_tx_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i) |=> (!tx_valid_o && $stable(tx_missed_o)));
endmodule

// File: tb/pkt_ts_latch_tb_top.sv
`timescale 1ns/1ps
module pkt_ts_latch_tb_top;
  localparam int unsigned MW = 3;
  localparam logic [MW-1:0] MMAX = {MW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] tm = '0;
  logic en [2];
  logic evt [2];
  logic rl [2];
  logic rh [2];
  logic vld [2];
  logic [31:0] rd [2];
  logic [MW-1:0] ms [2];

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pkt_ts_latch #(.TIME_W(64), .WORD_W(32), .MISS_W(MW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .time_i(tm),
    .tx_en_i(en[0]), .tx_evt_i(evt[0]), .tx_rd_lo_i(rl[0]), .tx_rd_hi_i(rh[0]),
    .tx_valid_o(vld[0]), .tx_rdata_o(rd[0]), .tx_missed_o(ms[0]),
    .rx_en_i(en[1]), .rx_evt_i(evt[1]), .rx_rd_lo_i(rl[1]), .rx_rd_hi_i(rh[1]),
    .rx_valid_o(vld[1]), .rx_rdata_o(rd[1]), .rx_missed_o(ms[1])
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    for (int c = 0; c < 2; c++) begin
      evt[c] = 1'b0; rl[c] = 1'b0; rh[c] = 1'b0;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] t1, t2, t3, t5, t6, t7;
    logic        ev, ex_v [2];
    logic [63:0] ex_s [2];
    logic [31:0] ex_r [2];
    logic [MW-1:0] ex_m [2];
    logic [31:0] lf;
    t1 = 64'h1111_2222_3333_4444; t2 = 64'h5555_6666_7777_8888;
    t3 = 64'h9999_AAAA_BBBB_CCCC; t5 = 64'hDEAD_0001_BEEF_0002;
    t6 = 64'h0F0F_1234_F0F0_5678; t7 = 64'hCAFE_0007_0070_0700;
    for (int c = 0; c < 2; c++) en[c] = 1'b0;
    idle();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    for (int c = 0; c < 2; c++) begin
      chk("R10 valid", 64'(vld[c]), 64'd0);
      chk("R10 rdata", 64'(rd[c]), 64'd0);
      chk("R10 missed", 64'(ms[c]), 64'd0);
    end
    en[0] = 1'b1; en[1] = 1'b1;
    tm = t1; evt[0] = 1'b1; tick(); idle();
    chk("R2 tx valid", 64'(vld[0]), 64'd1);
    chk("R9 rx valid", 64'(vld[1]), 64'd0);
    tm = t2; evt[0] = 1'b1; tick(); idle();
    chk("R3 valid held", 64'(vld[0]), 64'd1);
    chk("R7 missed one", 64'(ms[0]), 64'd1);
    rl[0] = 1'b1; tick(); idle();
    chk("R4 low half", 64'(rd[0]), 64'(t1[31:0]));
    chk("R6 low read keeps lock", 64'(vld[0]), 64'd1);
    rl[0] = 1'b1; rh[0] = 1'b1; tm = t3; evt[0] = 1'b1; tick(); idle();
    chk("R8 old high returned", 64'(rd[0]), 64'(t1[63:32]));
    chk("R8 valid kept", 64'(vld[0]), 64'd1);
    rl[0] = 1'b1; tick(); idle();
    chk("R8 new stamp low", 64'(rd[0]), 64'(t3[31:0]));
    rh[0] = 1'b1; tick(); idle();
    chk("R5 released", 64'(vld[0]), 64'd0);
    chk("R4 high half", 64'(rd[0]), 64'(t3[63:32]));
    en[0] = 1'b0; tm = t5; evt[0] = 1'b1; tick(); idle();
    chk("R1 no capture", 64'(vld[0]), 64'd0);
    en[0] = 1'b1; rl[0] = 1'b1; tick(); idle();
    chk("R1 stamp unchanged", 64'(rd[0]), 64'(t3[31:0]));
    tm = t5; evt[0] = 1'b1; tick(); idle();
    en[0] = 1'b0; tick();
    chk("R1 disable clears valid", 64'(vld[0]), 64'd0);
    en[0] = 1'b1; tm = t6; evt[0] = 1'b1; tick(); idle();
    chk("R1 lock cleared", 64'(vld[0]), 64'd1);
    for (int i = 0; i < 10; i++) begin
      evt[0] = 1'b1; tick(); idle();
    end
    chk("R7 saturated", 64'(ms[0]), 64'(MMAX));
    rh[0] = 1'b1; tick(); idle();
    chk("R3 stamp kept", 64'(rd[0]), 64'(t6[63:32]));
    tm = t7; evt[1] = 1'b1; tick(); idle();
    rh[1] = 1'b1; tick(); idle();
    chk("R9 rx high", 64'(rd[1]), 64'(t7[63:32]));
    chk("R9 rx missed", 64'(ms[1]), 64'd0);
    chk("R9 tx missed", 64'(ms[0]), 64'(MMAX));
    chk("R9 tx rdata", 64'(rd[0]), 64'(t6[63:32]));

    // sweep against a per-cycle reference model
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    for (int c = 0; c < 2; c++) begin
      ex_v[c] = 1'b0; ex_s[c] = '0; ex_r[c] = '0; ex_m[c] = '0;
    end
    lf = 32'h1ACE_B00C;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      for (int c = 0; c < 2; c++) begin
        chk("R2 R3 R5 sweep valid", 64'(vld[c]), 64'(ex_v[c]));
        chk("R4 R8 sweep rdata", 64'(rd[c]), 64'(ex_r[c]));
        chk("R7 sweep missed", 64'(ms[c]), 64'(ex_m[c]));
      end
      tm = {lf, lf ^ 32'(cyc)};
      for (int c = 0; c < 2; c++) begin
        lf = {1'b0, lf[31:1]} ^ (lf[0] ? 32'hA300_0000 : 32'h0);
        en[c]  = (lf[2:0] != 3'd0);
        evt[c] = (lf[4:3] == 2'd0) || (cyc > 3000 && lf[5]);
        rl[c]  = (lf[8:6] == 3'd1);
        rh[c]  = (lf[11:9] == 3'd2);
        if (rh[c])      ex_r[c] = ex_s[c][63:32];
        else if (rl[c]) ex_r[c] = ex_s[c][31:0];
        ev = en[c] && evt[c];
        if (ev && ex_v[c] && !rh[c] && ex_m[c] != MMAX) ex_m[c] = ex_m[c] + 1'b1;
        if (!en[c]) ex_v[c] = 1'b0;
        else if (ev && (!ex_v[c] || rh[c])) begin
          ex_s[c] = tm; ex_v[c] = 1'b1;
        end else if (rh[c]) ex_v[c] = 1'b0;
      end
      tick();
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule